// File: doc/BRIEF.md
# Buffered Modulus Up/Down Counter

This block is the counting core of one timer channel. It counts between 1 and an active modulus. In up-only mode it climbs to the modulus and wraps to 1. In up/down mode it climbs to the modulus, descends back to 1 and climbs again, tracing a triangle. The counter advances only on cycles where a one-cycle tick enable is high. That tick comes from a prescaled clock or from an input event, both produced outside the block.

Software never writes the active modulus directly. It writes a shadow register. The shadow value moves into the active modulus only at a cycle boundary, so a period is never cut short or stretched in the middle. A sticky flag marks match and boundary events, and it stays set until a clear pulse arrives. A load port sets the counter to any value, and counting then carries on from that value. This covers the case where the mode is entered while the counter holds an arbitrary value.

Top module: `bmc_counter`

## Requirements
- R1: With updown_i low, each tick increments count_o. A tick while count_o equals modulus_o sets count_o to 1, so the period is modulus_o ticks.
- R2: With updown_i high, count_o rises by one per tick up to modulus_o, then falls by one per tick down to 1, then rises again. The period is 2*modulus_o-2 ticks, and down_o is high while descending.
- R3: On a cycle with tick_i and load_i both low, count_o, down_o and modulus_o keep their values.
- R4: A cycle with shadow_we_i high stores shadow_data_i in the shadow register. modulus_o takes the shadow value only on the boundary tick. In up-only mode that is the tick that wraps to 1. In up/down mode it is the tick that brings count_o down to 1. A write in the same cycle as the boundary tick reaches modulus_o only at the following boundary.
- R5: With updown_i low, flag_o becomes 1 in the clock after every boundary tick.
- R6: With updown_i high, flag_o becomes 1 after every tick taken while ascending at count_o == modulus_o. It also becomes 1 after boundary ticks, but only when bnd_flag_i is high.
- R7: flag_o is registered and sticky. A cycle with flag_clr_i high clears it, unless a set event happens in the same cycle, in which case flag_o is 1.
- R8: load_i sets count_o to load_val_i in the next clock, taking priority over a tick. Later ticks continue from the loaded value.
- R9: After reset, count_o is 1, down_o is 0, flag_o is 0, and both modulus_o and the shadow register hold RESET_MOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle count enable |
| updown_i | input | 1 | 1 selects up/down mode, 0 selects up-only mode |
| bnd_flag_i | input | 1 | In up/down mode, also flag boundary ticks |
| load_i | input | 1 | Load the counter from load_val_i |
| load_val_i | input | W | Counter load value |
| shadow_we_i | input | 1 | Write strobe for the shadow modulus |
| shadow_data_i | input | W | Shadow modulus write data (values above 1) |
| flag_clr_i | input | 1 | Clear pulse for flag_o |
| count_o | output | W | Current count |
| down_o | output | 1 | Counter is descending |
| modulus_o | output | W | Active modulus |
| flag_o | output | 1 | Sticky event flag |

## Verification
The bench sweeps every modulus from 2 to 7 in up-only mode, and in up/down mode with the boundary flag option both off and on. For each case it compares each count and each flag against closed-form formulas over two full periods. These sweeps separate the two periods and expose off-by-one errors at the turning points, including the degenerate modulus 2, where match and boundary fall on the same tick. The gaps between ticks vary, which shows that idle cycles hold state. Directed sequences cover the rest: a shadow write mid-period and one on the boundary tick itself, loads into both modes, and a clear that arrives together with a set event.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/bmc_shadow.sv
module bmc_shadow #(
  parameter int unsigned W = 16,
  parameter int unsigned RESET_MOD = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  input  logic         bound_i,
  output logic [W-1:0] a1_o
);
  logic [W-1:0] a2_q, a1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a2_q <= W'(RESET_MOD);
      a1_q <= W'(RESET_MOD);
    end else begin
      if (we_i)    a2_q <= data_i;
      if (bound_i) a1_q <= a2_q;  // pre-write shadow value
    end
  end

  assign a1_o = a1_q;

  AST_A1_ONLY_AT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(a1_q)); // R4
endmodule

// File: rtl/bmc_core.sv
module bmc_core
  import bmc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         updown_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] a1_i,
  output logic [W-1:0] count_o,
  output logic         down_o,
  output logic         match_o,
  output logic         bound_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] cnt_q, cnt_d;
  dir_e         dir_q, dir_d;

  always_comb begin
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    match_o = 1'b0;
    bound_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      if (!updown_i) begin
        dir_d = DIR_UP;
        if (cnt_q == a1_i) begin
          cnt_d   = ONE;
          bound_o = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (dir_q == DIR_UP && cnt_q != a1_i) begin
        cnt_d = cnt_q + ONE;
      end else if (dir_q == DIR_DOWN && cnt_q <= ONE) begin
        cnt_d = cnt_q + ONE;
        dir_d = DIR_UP;
      end else begin
        // descending step, or turning point at A1
        match_o = (dir_q == DIR_UP);
        cnt_d   = cnt_q - ONE;
        if (cnt_q == TWO) begin
          bound_o = 1'b1;
          dir_d   = DIR_UP;
        end else begin
          dir_d   = DIR_DOWN;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ONE;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count_o = cnt_q;
  assign down_o  = (dir_q == DIR_DOWN);

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !updown_i && count_o == a1_i) |=> (count_o == ONE)); // R1
  AST_TURN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && updown_i && !down_o && count_o == a1_i && a1_i > TWO) |=> down_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> ($stable(count_o) && $stable(down_o))); // R3
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_val_i))); // R8
endmodule

// File: rtl/bmc_flag.sv
module bmc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic updown_i,
  input  logic bnd_flag_i,
  input  logic match_i,
  input  logic bound_i,
  input  logic clr_i,
  output logic flag_o
);
  logic set_evt, flag_q;

  assign set_evt = match_i | (bound_i & (~updown_i | bnd_flag_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_evt | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> flag_o); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_evt) |=> !flag_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_evt) |=> $stable(flag_o)); // R7
  AST_UP_BOUND_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i && !updown_i) |=> flag_o); // R5
endmodule

// File: rtl/bmc_counter.sv
module bmc_counter #(
  parameter int unsigned W = 16,
  parameter int unsigned RESET_MOD = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         updown_i,
  input  logic         bnd_flag_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shadow_we_i,
  input  logic [W-1:0] shadow_data_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] count_o,
  output logic         down_o,
  output logic [W-1:0] modulus_o,
  output logic         flag_o
);
  logic         match_w, bound_w;
  logic [W-1:0] a1_w;

  bmc_shadow #(.W(W), .RESET_MOD(RESET_MOD)) u_shadow (
    .clk_i, .rst_ni,
    .we_i   (shadow_we_i),
    .data_i (shadow_data_i),
    .bound_i(bound_w),
    .a1_o   (a1_w)
  );

  bmc_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .tick_i, .updown_i, .load_i, .load_val_i,
    .a1_i   (a1_w),
    .count_o,
    .down_o,
    .match_o(match_w),
    .bound_o(bound_w)
  );

  bmc_flag u_flag (
    .clk_i, .rst_ni, .updown_i, .bnd_flag_i,
    .match_i(match_w),
    .bound_i(bound_w),
    .clr_i  (flag_clr_i),
    .flag_o
  );

  assign modulus_o = a1_w;

  AST_UD_MATCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && updown_i && !down_o && count_o == modulus_o) |=> flag_o); // R6
endmodule

// File: tb/bmc_counter_tb_top.sv
`timescale 1ns/1ps
module bmc_counter_tb_top;
  localparam int W = 8;
  localparam int RMOD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, updown = 0, bnd_opt = 0, load = 0, we = 0, clr = 0;
  logic [W-1:0] load_val = '0, wdata = '0;
  logic [W-1:0] count, modulus;
  logic down, flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bmc_counter #(.W(W), .RESET_MOD(RMOD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .updown_i(updown),
    .bnd_flag_i(bnd_opt), .load_i(load), .load_val_i(load_val),
    .shadow_we_i(we), .shadow_data_i(wdata), .flag_clr_i(clr),
    .count_o(count), .down_o(down), .modulus_o(modulus), .flag_o(flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic do_write(input int v);
    @(negedge clk); we = 1; wdata = W'(v);
    @(negedge clk); we = 0;
  endtask

  task automatic do_load(input int v);
    @(negedge clk); load = 1; load_val = W'(v);
    @(negedge clk); load = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int per, pos, exp_cnt, exp_flag, pcnt;
    do_reset();
    // R9 reset state
    chk("R9 count", count, 1);
    chk("R9 down", down, 0);
    chk("R9 flag", flag, 0);
    chk("R9 modulus", modulus, RMOD);

    // sweep: mode x boundary option x modulus
    for (int md = 0; md < 2; md++) begin
      for (int op = 0; op <= md; op++) begin
        for (int m = 2; m <= 7; m++) begin
          do_reset();
          updown = md[0]; bnd_opt = op[0];
          do_write(m);
          for (int g = 0; g < 20 && modulus != W'(m); g++) do_tick();
          chk("R4 modulus taken at boundary", modulus, m);
          chk("R4 count at boundary", count, 1);
          do_clr();
          per = md ? 2*m-2 : m;
          for (int k = 1; k <= 2*per; k++) begin
            pcnt = count;
            for (int i = 0; i < k % 3; i++) @(negedge clk);
            chk("R3 idle hold", count, pcnt);
            do_tick();
            pos = k % per;
            if (md == 0) exp_cnt = pos + 1;
            else exp_cnt = (pos < m) ? pos + 1 : 2*m - 1 - pos;
            exp_flag = (((k-1) % per) == m-1) ? 1 : 0;
            if (md == 1 && op == 1 && pos == 0) exp_flag = 1;
            if (md == 0) begin
              chk("R1 up count", count, exp_cnt);
              chk("R5 boundary flag", flag, exp_flag);
            end else begin
              chk("R2 updown count", count, exp_cnt);
              chk("R2 direction", down, (pos >= m) ? 1 : 0);
              chk("R6 updown flag", flag, exp_flag);
            end
            if (flag) begin
              do_clr();
              chk("R7 clear", flag, 0);
            end
          end
        end
      end
    end

    // R4 buffering: mid-period write, and write on the boundary tick
    do_reset(); updown = 0; bnd_opt = 0;
    do_tick(); do_tick();
    do_write(6);
    chk("R4 no early transfer", modulus, 4);
    do_tick();
    chk("R4 still old at A1", modulus, 4);
    do_tick();
    chk("R4 transfer", modulus, 6);
    chk("R1 wrap", count, 1);
    for (int i = 0; i < 5; i++) do_tick();
    chk("R1 reach new A1", count, 6);
    @(negedge clk); tick = 1; we = 1; wdata = W'(3);
    @(negedge clk); tick = 0; we = 0;
    chk("R4 same-cycle write deferred", modulus, 6);
    chk("R1 wrap at 6", count, 1);
    for (int i = 0; i < 6; i++) do_tick();
    chk("R4 deferred value applied", modulus, 3);

    // R7 sticky across non-event ticks, set wins over clear
    chk("R7 sticky flag", flag, 1);
    do_tick();
    chk("R7 flag held", flag, 1);
    do_tick(); // count 3 = A1
    @(negedge clk); tick = 1; clr = 1;
    @(negedge clk); tick = 0; clr = 0;
    chk("R7 set wins", flag, 1);
    chk("R1 wrap at 3", count, 1);
    do_clr();
    chk("R7 cleared", flag, 0);

    // R8 load in up mode, A1 = 3
    do_load(2);
    chk("R8 loaded", count, 2);
    do_tick();
    chk("R8 continue", count, 3);
    do_tick();
    chk("R8 wrap after load", count, 1);
    // load beats tick
    @(negedge clk); tick = 1; load = 1; load_val = W'(3);
    @(negedge clk); tick = 0; load = 0;
    chk("R8 load priority", count, 3);

    // R8 load in up/down mode at A1 = 3
    do_clr();
    updown = 1; bnd_opt = 1;
    do_tick();
    chk("R2 turn from load", count, 2);
    chk("R2 down after turn", down, 1);
    chk("R6 match flag", flag, 1);
    do_clr();
    do_tick();
    chk("R2 reach 1", count, 1);
    chk("R2 up at 1", down, 0);
    chk("R6 boundary flag opt", flag, 1);

    done = 1;
    finish_run();
  end
endmodule